// File: doc/BRIEF.md
# Branch History Rolling Buffer

This block keeps a rolling window of the most recent branch-history records, each 64 bits wide, in a ring of `DEPTH` slots. A recording port pushes one record per cycle into the slot under the write pointer and then advances the pointer. Once the ring is full, each new record replaces the oldest one. Software reaches the ring through a command port with two operations. A read takes a 10-bit index that counts back from the newest record. A clear wipes the whole ring.

Every command passes a two-level permission check before it acts. The first level is a hypervisor facility-enable bit. The second level applies only in problem (user) state and is a buffer-available bit in the monitor control register. When a command is denied, the block raises a facility-unavailable fault with a fixed cause code one cycle later, and the command changes nothing. A granted read answers one cycle later with a valid strobe. The answer is zero in four cases: the index is out of range, the monitor alert-enable bit is set, history recording is disabled at build time, or the slot has never been written.

Top module: `brb_history_buf`

## Requirements
- R1: After reset, all slots are zero, `rd_valid`, `fault_valid` and `fault_hyp` are low, and `fault_cause` is zero.
- R2: A cycle with `rec_valid` high writes `rec_data` into the slot under the write pointer and advances the pointer modulo `DEPTH`, so the record pushed `DEPTH` pushes earlier is overwritten.
- R3: A granted read (`cmd_op` = 0) with index k below `DEPTH` returns the record at slot (pointer − k − 1) mod `DEPTH`; index 0 is the newest record.
- R4: A granted read with index greater than or equal to `DEPTH` (up to 1023) returns zero with `rd_valid` high.
- R5: A granted read issued while `mon_alert_en` is high returns zero with `rd_valid` high.
- R6: A granted clear (`cmd_op` = 1) sets every slot to zero and returns the write pointer to slot 0.
- R7: A command issued while `hv_fac_en` is low is denied. One cycle later `fault_valid` and `fault_hyp` are high, `fault_cause` equals `FAULT_CAUSE` (default 4'd9), and `rd_valid` stays low. The ring is left unchanged.
- R8: A command issued with `hv_fac_en` high, `problem_st` high and `mon_avail` low is denied. It faults as in R7 except that `fault_hyp` is low. Outside problem state, `mon_avail` has no effect.
- R9: `rd_valid` is a one-cycle pulse in the cycle after a granted read. `rd_data` is zero whenever `rd_valid` is low.
- R10: A clear and a record in the same cycle leave the ring empty, because the clear wins. A read in the same cycle as a record returns the contents from before that record.
- R11: With `RECORD_EN` = 0, commands still execute and are still permission-checked, but every read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid | input | 1 | Push a record this cycle |
| rec_data | input | 64 | Record to push |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 1 | 0 = read, 1 = clear |
| cmd_index | input | 10 | Read index, newest first |
| hv_fac_en | input | 1 | Hypervisor facility enable for the buffer |
| problem_st | input | 1 | Command issued in problem (user) state |
| mon_avail | input | 1 | Buffer-available bit of the monitor control |
| mon_alert_en | input | 1 | Monitor alert-enable bit; forces zero reads |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| fault_valid | output | 1 | Facility-unavailable fault |
| fault_hyp | output | 1 | Fault came from the hypervisor-level check |
| fault_cause | output | 4 | Fault cause code |

## Verification
A write pointer that is stuck or skips a slot shows up at the ports as soon as the newest records are read back. Index 0 then returns an older or a stale record instead of the last push, and after wrap-around a read of index `DEPTH`−1 exposes the overwrite order. A corrupted slot or a clear that only partly acts appears on the first read of that index, one cycle after the command. A wrong gate decision shows up one cycle after the offending command, as a missing or spurious fault strobe or read strobe. Any effect that a denied command had on the ring appears on the next granted read of the affected slot.

// File: rtl/brb_pkg.sv
package brb_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_CLEAR = 1'b1
  } brb_op_e;
endpackage

// File: rtl/brb_access_gate.sv
// Two-level permission check: hypervisor enable first, then user-state availability.
module brb_access_gate (
  input  logic cmd_valid,
  input  logic hv_fac_en,
  input  logic problem_st,
  input  logic mon_avail,
  output logic grant,
  output logic deny,
  output logic deny_hyp
);
  logic deny_user;

  always_comb begin
    deny_hyp  = cmd_valid & ~hv_fac_en;
    deny_user = cmd_valid & hv_fac_en & problem_st & ~mon_avail;
    deny      = deny_hyp | deny_user;
    grant     = cmd_valid & ~deny;
  end
endmodule

// File: rtl/brb_slot_map.sv
// Maps a newest-first index onto a physical slot relative to the write pointer.
module brb_slot_map #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 10,
  parameter int PTR_W = 3
) (
  input  logic [PTR_W-1:0] wptr,
  input  logic [IDX_W-1:0] idx,
  output logic [PTR_W-1:0] slot,
  output logic             in_range
);
  localparam int SW = IDX_W + 2;

  logic [SW-1:0] sum;

  always_comb begin
    in_range = ({2'b00, idx} < SW'(DEPTH));
    sum      = SW'(wptr) + SW'(DEPTH - 1) - {2'b00, idx};
    if (sum >= SW'(DEPTH)) begin
      slot = PTR_W'(sum - SW'(DEPTH));
    end else begin
      slot = PTR_W'(sum);
    end
  end
endmodule

// File: rtl/brb_store.sv
// Ring storage with write pointer; clear has priority over a push.
module brb_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 64,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              clear,
  input  logic [PTR_W-1:0]  rd_slot,
  output logic [DATA_W-1:0] rd_entry,
  output logic [PTR_W-1:0]  wptr
);
  logic [PTR_W-1:0]  wptr_q, wptr_d;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_comb begin
    wptr_d = wptr_q;
    if (clear) begin
      wptr_d = '0;
    end else if (push) begin
      wptr_d = (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
    end else if (clear || push) begin
      wptr_q <= wptr_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              en;
    logic [DATA_W-1:0] ent_d;

    always_comb begin
      en    = clear | (push & (wptr_q == PTR_W'(g)));
      ent_d = clear ? '0 : push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (en) begin
        mem_q[g] <= ent_d;
      end
    end
  end

  assign rd_entry = mem_q[rd_slot];
  assign wptr     = wptr_q;
endmodule

// File: rtl/brb_history_buf.sv
module brb_history_buf #(
  parameter int          DEPTH       = 8,
  parameter int          DATA_W      = 64,
  parameter int          IDX_W       = 10,
  parameter int          CAUSE_W     = 4,
  parameter logic [3:0]  FAULT_CAUSE = 4'd9,
  parameter bit          RECORD_EN   = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rec_valid,
  input  logic [DATA_W-1:0]  rec_data,
  input  logic               cmd_valid,
  input  logic               cmd_op,
  input  logic [IDX_W-1:0]   cmd_index,
  input  logic               hv_fac_en,
  input  logic               problem_st,
  input  logic               mon_avail,
  input  logic               mon_alert_en,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data,
  output logic               fault_valid,
  output logic               fault_hyp,
  output logic [CAUSE_W-1:0] fault_cause
);
  import brb_pkg::*;

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              grant, deny, deny_hyp;
  logic              rd_go, clr_go;
  logic [PTR_W-1:0]  wptr, rd_slot;
  logic              in_range;
  logic [DATA_W-1:0] rd_entry, rd_src;

  logic               rd_valid_q, rd_valid_d;
  logic [DATA_W-1:0]  rd_data_q, rd_data_d;
  logic               fault_q, fault_d;
  logic               fhyp_q, fhyp_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;

  brb_access_gate u_gate (
    .cmd_valid (cmd_valid),
    .hv_fac_en (hv_fac_en),
    .problem_st(problem_st),
    .mon_avail (mon_avail),
    .grant     (grant),
    .deny      (deny),
    .deny_hyp  (deny_hyp)
  );

  assign rd_go  = grant & (brb_op_e'(cmd_op) == OP_READ);
  assign clr_go = grant & (brb_op_e'(cmd_op) == OP_CLEAR);

  brb_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (rec_valid),
    .push_data(rec_data),
    .clear    (clr_go),
    .rd_slot  (rd_slot),
    .rd_entry (rd_entry),
    .wptr     (wptr)
  );

  brb_slot_map #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_map (
    .wptr    (wptr),
    .idx     (cmd_index),
    .slot    (rd_slot),
    .in_range(in_range)
  );

  if (RECORD_EN) begin : g_rec
    assign rd_src = rd_entry;
  end else begin : g_norec
    assign rd_src = '0;
  end

  always_comb begin
    rd_valid_d = rd_go;
    rd_data_d  = (rd_go && in_range && !mon_alert_en) ? rd_src : '0;
    fault_d    = deny;
    fhyp_d     = deny_hyp;
    cause_d    = deny ? CAUSE_W'(FAULT_CAUSE) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      fault_q    <= 1'b0;
      fhyp_q     <= 1'b0;
      cause_q    <= '0;
    end else begin
      rd_valid_q <= rd_valid_d;
      rd_data_q  <= rd_data_d;
      fault_q    <= fault_d;
      fhyp_q     <= fhyp_d;
      cause_q    <= cause_d;
    end
  end

  assign rd_valid    = rd_valid_q;
  assign rd_data     = rd_data_q;
  assign fault_valid = fault_q;
  assign fault_hyp   = fhyp_q;
  assign fault_cause = cause_q;
endmodule

// File: rtl/brb_history_buf_chk.sv
module brb_history_buf_chk #(
  parameter int         DEPTH       = 8,
  parameter int         DATA_W      = 64,
  parameter int         IDX_W       = 10,
  parameter int         CAUSE_W     = 4,
  parameter logic [3:0] FAULT_CAUSE = 4'd9,
  parameter int         PTR_W       = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rec_valid,
  input logic               cmd_valid,
  input logic               cmd_op,
  input logic [IDX_W-1:0]   cmd_index,
  input logic               mon_alert_en,
  input logic               clr_go,
  input logic [PTR_W-1:0]   wptr,
  input logic               rd_valid,
  input logic [DATA_W-1:0]  rd_data,
  input logic               fault_valid,
  input logic               fault_hyp,
  input logic [CAUSE_W-1:0] fault_cause
);
  p_read_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && !cmd_op));

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == '0);

  p_oor_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_op && (cmd_index >= IDX_W'(DEPTH))) |=> rd_data == '0);

  p_alert_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && mon_alert_en) |=> rd_data == '0);

  p_fault_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (!rd_valid && fault_cause == CAUSE_W'(FAULT_CAUSE)));

  p_quiet_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_valid |-> (fault_cause == '0 && !fault_hyp));

  p_clear_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_go |=> wptr == '0);

  p_ptr_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !clr_go && (DEPTH > 1)) |=> wptr != $past(wptr));
endmodule

bind brb_history_buf brb_history_buf_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W), .CAUSE_W(CAUSE_W),
  .FAULT_CAUSE(FAULT_CAUSE), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .cmd_index(cmd_index), .mon_alert_en(mon_alert_en),
  .clr_go(clr_go), .wptr(wptr), .rd_valid(rd_valid), .rd_data(rd_data),
  .fault_valid(fault_valid), .fault_hyp(fault_hyp), .fault_cause(fault_cause)
);

// File: tb/brb_history_buf_tb_top.sv
module brb_history_buf_tb_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rec_valid, cmd_valid, cmd_op;
  logic [63:0] rec_data;
  logic [9:0]  cmd_index;
  logic        hv_fac_en, problem_st, mon_avail, mon_alert_en;
  logic        rd_valid, fault_valid, fault_hyp;
  logic [63:0] rd_data;
  logic [3:0]  fault_cause;
  logic        nr_rd_valid, nr_fault_valid, nr_fault_hyp;
  logic [63:0] nr_rd_data;
  logic [3:0]  nr_fault_cause;

  int checks = 0;
  int errors = 0;
  logic [63:0] model [N];
  int mw = 0;

  always #2.5 clk = ~clk;

  brb_history_buf #(.DEPTH(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_data(rec_data),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_index(cmd_index),
    .hv_fac_en(hv_fac_en), .problem_st(problem_st), .mon_avail(mon_avail),
    .mon_alert_en(mon_alert_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .fault_valid(fault_valid), .fault_hyp(fault_hyp), .fault_cause(fault_cause)
  );

  brb_history_buf #(.DEPTH(N), .RECORD_EN(1'b0)) dut_norec_i (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_data(rec_data),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_index(cmd_index),
    .hv_fac_en(hv_fac_en), .problem_st(problem_st), .mon_avail(mon_avail),
    .mon_alert_en(mon_alert_en), .rd_valid(nr_rd_valid), .rd_data(nr_rd_data),
    .fault_valid(nr_fault_valid), .fault_hyp(nr_fault_hyp), .fault_cause(nr_fault_cause)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] expect_rd(int idx);
    if (idx >= N || mon_alert_en) return 64'd0;
    return model[(mw + N - 1 - idx) % N];
  endfunction

  task automatic push(logic [63:0] d);
    @(negedge clk);
    rec_valid = 1'b1; rec_data = d;
    @(negedge clk);
    rec_valid = 1'b0;
    model[mw] = d;
    mw = (mw + 1) % N;
  endtask

  task automatic issue(logic op, int idx);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_index = 10'(idx);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic read_ok(string req, int idx);
    logic [63:0] e;
    e = expect_rd(idx);
    issue(1'b0, idx);
    chk(req, "rd_valid", 64'(rd_valid), 64'd1);
    chk(req, $sformatf("rd_data[%0d]", idx), rd_data, e);
    chk(req, "no fault", 64'(fault_valid), 64'd0);
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) model[i] = 64'd0;
    mw = 0;
  endtask

  task automatic t_reset();
    chk("R1", "rd_valid at reset", 64'(rd_valid), 64'd0);
    chk("R1", "fault at reset", 64'(fault_valid), 64'd0);
    chk("R1", "cause at reset", 64'(fault_cause), 64'd0);
    chk("R1", "hyp at reset", 64'(fault_hyp), 64'd0);
    for (int i = 0; i < N; i++) read_ok("R1", i);
  endtask

  task automatic t_push_order();
    for (int i = 0; i < 3; i++) push(64'hA5A5_0000_0000_0010 + 64'(i));
    for (int i = 0; i < 3; i++) read_ok("R3", i);
    for (int i = 0; i < 10; i++) push(64'h1234_5678_0000_0100 + 64'(i * 7));
    for (int i = 0; i < N; i++) read_ok("R2", i);
  endtask

  task automatic t_pulse();
    issue(1'b0, 0);
    @(negedge clk);
    chk("R9", "rd_valid one-cycle pulse", 64'(rd_valid), 64'd0);
    chk("R9", "rd_data zero when idle", rd_data, 64'd0);
  endtask

  task automatic t_out_of_range();
    read_ok("R4", N);
    read_ok("R4", 1023);
  endtask

  task automatic t_alert();
    mon_alert_en = 1'b1;
    read_ok("R5", 0);
    read_ok("R5", 3);
    mon_alert_en = 1'b0;
    read_ok("R5", 0);
  endtask

  task automatic t_hyp_fault();
    hv_fac_en = 1'b0;
    issue(1'b0, 0);
    chk("R7", "fault_valid", 64'(fault_valid), 64'd1);
    chk("R7", "fault_hyp", 64'(fault_hyp), 64'd1);
    chk("R7", "fault_cause", 64'(fault_cause), 64'd9);
    chk("R7", "no rd_valid", 64'(rd_valid), 64'd0);
    issue(1'b1, 0);
    chk("R7", "clear denied", 64'(fault_valid), 64'd1);
    hv_fac_en = 1'b1;
    for (int i = 0; i < N; i++) read_ok("R7", i);
  endtask

  task automatic t_user_fault();
    problem_st = 1'b1; mon_avail = 1'b0;
    issue(1'b0, 1);
    chk("R8", "fault_valid", 64'(fault_valid), 64'd1);
    chk("R8", "fault_hyp low", 64'(fault_hyp), 64'd0);
    chk("R8", "fault_cause", 64'(fault_cause), 64'd9);
    chk("R8", "no rd_valid", 64'(rd_valid), 64'd0);
    issue(1'b1, 0);
    chk("R8", "clear denied", 64'(fault_valid), 64'd1);
    mon_avail = 1'b1;
    read_ok("R8", 1);
    problem_st = 1'b0; mon_avail = 1'b0;
    read_ok("R8", 2);
    mon_avail = 1'b1;
  endtask

  task automatic t_clear();
    issue(1'b1, 0);
    chk("R6", "clear no fault", 64'(fault_valid), 64'd0);
    chk("R6", "clear no rd_valid", 64'(rd_valid), 64'd0);
    model_clear();
    for (int i = 0; i < N; i++) read_ok("R6", i);
    push(64'hDEAD_BEEF_0000_0001);
    read_ok("R6", 0);
    read_ok("R6", 1);
  endtask

  task automatic t_same_cycle();
    push(64'h0BAD_F00D_0000_0002);
    @(negedge clk);
    rec_valid = 1'b1; rec_data = 64'h7777_0000_0000_0003;
    cmd_valid = 1'b1; cmd_op = 1'b0; cmd_index = 10'd0;
    @(negedge clk);
    rec_valid = 1'b0; cmd_valid = 1'b0;
    chk("R10", "read sees prior newest", rd_data, 64'h0BAD_F00D_0000_0002);
    model[mw] = 64'h7777_0000_0000_0003; mw = (mw + 1) % N;
    read_ok("R10", 0);
    @(negedge clk);
    rec_valid = 1'b1; rec_data = 64'h5555_0000_0000_0004;
    cmd_valid = 1'b1; cmd_op = 1'b1;
    @(negedge clk);
    rec_valid = 1'b0; cmd_valid = 1'b0;
    model_clear();
    for (int i = 0; i < N; i++) read_ok("R10", i);
  endtask

  task automatic t_norec();
    push(64'hCAFE_0000_0000_0005);
    issue(1'b0, 0);
    chk("R11", "rd_valid", 64'(nr_rd_valid), 64'd1);
    chk("R11", "rd_data zero", nr_rd_data, 64'd0);
    chk("R11", "recording copy nonzero", rd_data, 64'hCAFE_0000_0000_0005);
    hv_fac_en = 1'b0;
    issue(1'b0, 0);
    chk("R11", "still gated", 64'(nr_fault_valid), 64'd1);
    hv_fac_en = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rec_valid = 1'b0; rec_data = '0; cmd_valid = 1'b0;
    cmd_op = 1'b0; cmd_index = '0; hv_fac_en = 1'b1; problem_st = 1'b0;
    mon_avail = 1'b1; mon_alert_en = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push_order();
    t_pulse();
    t_out_of_range();
    t_alert();
    t_hyp_fault();
    t_user_fault();
    t_clear();
    t_same_cycle();
    t_norec();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule